// File: doc/BRIEF.md
# Descriptor Pointer Fetch Queue

This block keeps, for one channel, an ordered list of pointers to descriptors held in memory. A host processor adds a pointer by writing a 64-bit register through a port with a byte enable for each byte. The channel's descriptor fetch engine is then given those pointers one at a time. Each handoff is a single-cycle launch pulse that carries the pointer. The next handoff waits until the engine reports that the current descriptor is done.

When extended addressing is switched on, a 4-bit upper address portion is added to the 32-bit address to form a 36-bit pointer. That portion can be written together with the low address, or in an earlier write, where it is staged until used. A pointer whose 32-bit address is zero is not stored in the queue. Instead it puts the channel into a sticky error halt, and no launches happen until the error is cleared. A push into a full queue is discarded and raises a sticky overflow flag.

Top module: `dpq_fetch_queue`

## Requirements
- R1: After reset the occupancy count is 0, no launch is issued, both sticky flags are low and the staged extended portion is 0.
- R2: A register write adds an entry only when byte enable bit 0 is set. A write without bit 0 leaves the occupancy unchanged and launches nothing.
- R3: Write data bits 31..0 are the fetch address and bits 35..32 are the extended portion. Bits 63..36 have no effect on any output.
- R4: A write with byte enable bit 4 set loads bits 35..32 into a staging register, which holds its value until written again. With `ext_addr_en` high when an entry is added, the pointer is {extended portion, address}. If the same write also sets byte enable bit 4, the newly written portion is used.
- R5: With `ext_addr_en` low when an entry is added, pointer bits 35..32 are zero.
- R6: `launch_valid` is a one-cycle pulse. It is issued in the cycle after the channel is found idle, with no error and a non-empty queue. Entries leave the queue in the order they were written. The channel becomes busy at a launch and idle again on `desc_done`. An entry added to an empty, idle channel is launched one cycle after it is written. A `desc_done` is followed by the next launch one cycle later.
- R7: A write adding an address of zero sets `err_halt` and does not add an entry. While `err_halt` is high, no launches are issued and the queue keeps its contents.
- R8: The queue holds at most 24 entries, and `fill_count` shows 0 to 24. An add while 24 entries are held is dropped and sets `ovf_sticky`, unless a launch removes an entry in the same cycle, in which case the add is accepted.
- R9: `err_clear` clears both `err_halt` and `ovf_sticky`. It does not change the queue contents. If a zero address is written in the same cycle, the error is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low channel reset |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 8 | Byte enables of the write |
| reg_wdata | input | 64 | Write data |
| ext_addr_en | input | 1 | Extended addressing enable |
| err_clear | input | 1 | Clears the error halt and the overflow flag |
| desc_done | input | 1 | Current descriptor finished |
| launch_valid | output | 1 | One-cycle launch pulse |
| launch_ptr | output | 36 | Pointer launched, valid with `launch_valid` |
| err_halt | output | 1 | Sticky zero-address error, channel halted |
| ovf_sticky | output | 1 | Sticky dropped-push flag |
| fill_count | output | 5 | Entries held in the queue |

## Verification
The main push-and-launch path is driven with three kinds of traffic.

- **Single writes at an idle channel.** These separate the startup launch from a launch triggered by `desc_done`.
- **Bursts written while the engine is busy.** These fill the queue to its limit and check overflow, order, and the accept-when-popping case at the full boundary.
- **Writes with mixed byte enables.** Low-byte-only, extended-byte-only and combined writes, each with extended addressing on and off, show whether the staged portion, the freshly written portion, or zero ends up in the pointer.

Zero addresses are written both at an idle channel and behind queued entries, to show that the halt stops launches without losing queued pointers.

// File: rtl/dpq_pkg.sv
package dpq_pkg;
   localparam int unsigned DPQ_REG_W  = 64;
   localparam int unsigned DPQ_ADDR_W = 32;
   localparam int unsigned DPQ_EXT_W  = 4;
   localparam int unsigned DPQ_DEPTH  = 24;

   // next circular index with wrap at an arbitrary depth
   function automatic int unsigned dpq_next_idx(input int unsigned idx, input int unsigned depth);
      return (idx == depth - 1) ? 0 : idx + 1;
   endfunction
endpackage

// File: rtl/dpq_ext_stage.sv
module dpq_ext_stage #(
   parameter int unsigned REG_W  = dpq_pkg::DPQ_REG_W,
   parameter int unsigned ADDR_W = dpq_pkg::DPQ_ADDR_W,
   parameter int unsigned EXT_W  = dpq_pkg::DPQ_EXT_W,
   localparam int unsigned BE_W  = REG_W / 8,
   localparam int unsigned PTR_W = ADDR_W + EXT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [BE_W-1:0]  reg_be,
   input  logic [REG_W-1:0] reg_wdata,
   input  logic             ext_addr_en,
   output logic             push_req,
   output logic             push_zero,
   output logic [PTR_W-1:0] push_ptr
);
   localparam int unsigned EXT_LANE = ADDR_W / 8;

   initial begin
      if (ADDR_W % 8 != 0) $error("dpq_ext_stage: ADDR_W must be a byte multiple");
      if (EXT_W > 8) $error("dpq_ext_stage: EXT_W must fit in one byte lane");
      if (PTR_W > REG_W) $error("dpq_ext_stage: pointer wider than register");
   end

   logic [ADDR_W-1:0] addr_fld;
   assign addr_fld  = reg_wdata[ADDR_W-1:0];
   assign push_req  = reg_wr && reg_be[0];
   assign push_zero = push_req && (addr_fld == '0);

   generate
      if (EXT_W > 0) begin : g_ext
         logic [EXT_W-1:0] ext_q;
         logic [EXT_W-1:0] ext_eff;
         logic             ext_wr;

         assign ext_wr  = reg_wr && reg_be[EXT_LANE];
         assign ext_eff = ext_wr ? reg_wdata[ADDR_W +: EXT_W] : ext_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      ext_q <= '0;
            else if (ext_wr) ext_q <= reg_wdata[ADDR_W +: EXT_W];
         end

         assign push_ptr = {(ext_addr_en ? ext_eff : {EXT_W{1'b0}}), addr_fld};

         // R4: the staged portion only changes on a write that covers its byte lane
         a_r4_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !ext_wr |=> $stable(ext_q));
      end else begin : g_noext
         logic unused_en;
         assign unused_en = ext_addr_en;
         assign push_ptr  = addr_fld;
      end
   endgenerate
endmodule

// File: rtl/dpq_ptr_fifo.sv
module dpq_ptr_fifo #(
   parameter int unsigned WIDTH = 36,
   parameter int unsigned DEPTH = dpq_pkg::DPQ_DEPTH,
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             nonempty,
   output logic             drop,
   output logic [CNT_W-1:0] count
);
   initial begin
      if (DEPTH < 2) $error("dpq_ptr_fifo: DEPTH must be at least 2");
      if (WIDTH < 1) $error("dpq_ptr_fifo: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [IDX_W-1:0] wr_idx, rd_idx;
   logic             full, do_push, do_pop;

   assign full     = (count == CNT_W'(DEPTH));
   assign nonempty = (count != '0);
   assign do_pop   = pop && nonempty;
   assign do_push  = push && (!full || do_pop);
   assign drop     = push && !do_push;
   assign head     = mem[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_idx <= '0;
         rd_idx <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_idx <= IDX_W'(dpq_pkg::dpq_next_idx(32'(wr_idx), DEPTH));
         if (do_pop)  rd_idx <= IDX_W'(dpq_pkg::dpq_next_idx(32'(rd_idx), DEPTH));
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_idx] <= din;
   end

   // R8: occupancy never exceeds the capacity
   a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   // R8: a dropped push leaves occupancy unchanged
   a_r8_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (count == CNT_W'(DEPTH)));
   // R2: with neither push nor pop, occupancy holds
   a_r2_idle_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!push && !pop) |=> $stable(count));
endmodule

// File: rtl/dpq_launch_ctl.sv
module dpq_launch_ctl #(
   parameter int unsigned PTR_W = 36
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             nonempty,
   input  logic [PTR_W-1:0] head,
   input  logic             desc_done,
   input  logic             err_clear,
   input  logic             zero_evt,
   input  logic             drop_evt,
   output logic             pop,
   output logic             launch_valid,
   output logic [PTR_W-1:0] launch_ptr,
   output logic             err_halt,
   output logic             ovf_sticky
);
   logic busy_q;

   assign pop = !busy_q && !err_halt && nonempty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q       <= 1'b0;
         launch_valid <= 1'b0;
         launch_ptr   <= '0;
         err_halt     <= 1'b0;
         ovf_sticky   <= 1'b0;
      end else begin
         launch_valid <= pop;
         if (pop) begin
            launch_ptr <= head;
            busy_q     <= 1'b1;
         end else if (desc_done) begin
            busy_q     <= 1'b0;
         end
         if (zero_evt)       err_halt <= 1'b1;
         else if (err_clear) err_halt <= 1'b0;
         if (drop_evt)       ovf_sticky <= 1'b1;
         else if (err_clear) ovf_sticky <= 1'b0;
      end
   end

   // R6: launch is a single-cycle pulse
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      launch_valid |=> !launch_valid);
   // R7: a halted channel issues no launch
   a_r7_no_launch_halted: assert property (@(posedge clk) disable iff (!rst_n)
      err_halt |=> !launch_valid);
   // R7: error stays until cleared
   a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_halt && !err_clear) |=> err_halt);
   // R8: overflow stays until cleared
   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_sticky && !err_clear) |=> ovf_sticky);
endmodule

// File: rtl/dpq_fetch_queue.sv
module dpq_fetch_queue #(
   parameter int unsigned REG_W  = dpq_pkg::DPQ_REG_W,
   parameter int unsigned ADDR_W = dpq_pkg::DPQ_ADDR_W,
   parameter int unsigned EXT_W  = dpq_pkg::DPQ_EXT_W,
   parameter int unsigned DEPTH  = dpq_pkg::DPQ_DEPTH,
   localparam int unsigned BE_W  = REG_W / 8,
   localparam int unsigned PTR_W = ADDR_W + EXT_W,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [BE_W-1:0]  reg_be,
   input  logic [REG_W-1:0] reg_wdata,
   input  logic             ext_addr_en,
   input  logic             err_clear,
   input  logic             desc_done,
   output logic             launch_valid,
   output logic [PTR_W-1:0] launch_ptr,
   output logic             err_halt,
   output logic             ovf_sticky,
   output logic [CNT_W-1:0] fill_count
);
   initial begin
      if (REG_W % 8 != 0) $error("dpq_fetch_queue: REG_W must be a byte multiple");
   end

   logic             push_req, push_zero, fifo_drop, fifo_nonempty, fifo_pop;
   logic [PTR_W-1:0] push_ptr, fifo_head;

   dpq_ext_stage #(.REG_W(REG_W), .ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_stage (
      .clk, .rst_n, .reg_wr, .reg_be, .reg_wdata, .ext_addr_en,
      .push_req, .push_zero, .push_ptr);

   dpq_ptr_fifo #(.WIDTH(PTR_W), .DEPTH(DEPTH)) u_fifo (
      .clk, .rst_n,
      .push(push_req && !push_zero), .din(push_ptr),
      .pop(fifo_pop), .head(fifo_head), .nonempty(fifo_nonempty),
      .drop(fifo_drop), .count(fill_count));

   dpq_launch_ctl #(.PTR_W(PTR_W)) u_ctl (
      .clk, .rst_n, .nonempty(fifo_nonempty), .head(fifo_head),
      .desc_done, .err_clear, .zero_evt(push_zero), .drop_evt(fifo_drop),
      .pop(fifo_pop), .launch_valid, .launch_ptr, .err_halt, .ovf_sticky);

   // R7: a zero address is never handed to the fetch engine
   a_r7_nonzero_launch: assert property (@(posedge clk) disable iff (!rst_n)
      launch_valid |-> (launch_ptr[ADDR_W-1:0] != '0));
   // R2: a write without the low byte lane leaves occupancy as is when no launch pops
   a_r2_no_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_be[0] && !fifo_pop) |=> $stable(fill_count));
endmodule

// File: tb/dpq_fetch_queue_tb.sv
module dpq_fetch_queue_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_be = '0;
   logic [63:0] reg_wdata = '0;
   logic        ext_addr_en = 1'b0;
   logic        err_clear = 1'b0;
   logic        desc_done = 1'b0;
   logic        launch_valid;
   logic [35:0] launch_ptr;
   logic        err_halt, ovf_sticky;
   logic [4:0]  fill_count;

   int n_vec = 0;
   int n_bad = 0;

   // reference model state
   logic [35:0] mq[$];
   logic [3:0]  m_ext = '0;
   bit          m_busy = 0, m_err = 0, m_ovf = 0, m_lv = 0;
   logic [35:0] m_lp = '0;
   logic [35:0] last_launch = '0;

   always #4 clk = ~clk;

   dpq_fetch_queue u_dut (
      .clk, .rst_n, .reg_wr, .reg_be, .reg_wdata, .ext_addr_en, .err_clear,
      .desc_done, .launch_valid, .launch_ptr, .err_halt, .ovf_sticky, .fill_count);

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_step();
      bit launch, wr_ext, wr_lo;
      logic [3:0] ext_eff;
      logic [35:0] p;
      launch = !m_busy && !m_err && (mq.size() > 0);
      m_lv = launch;
      if (launch) begin
         m_lp = mq.pop_front();
         m_busy = 1;
      end else if (desc_done) m_busy = 0;
      wr_ext = reg_wr && reg_be[4];
      wr_lo  = reg_wr && reg_be[0];
      ext_eff = wr_ext ? reg_wdata[35:32] : m_ext;
      if (wr_ext) m_ext = reg_wdata[35:32];
      if (err_clear) begin m_err = 0; m_ovf = 0; end
      if (wr_lo) begin
         p = {(ext_addr_en ? ext_eff : 4'h0), reg_wdata[31:0]};
         if (reg_wdata[31:0] == 0) m_err = 1;
         else if (mq.size() < 24) mq.push_back(p);
         else m_ovf = 1;
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      #2;
      chk("R6 launch_valid", 64'(launch_valid), 64'(m_lv));
      if (m_lv) begin
         chk("R6 launch_ptr order", 64'(launch_ptr), 64'(m_lp));
         last_launch = launch_ptr;
      end
      chk("R8 fill_count", 64'(fill_count), 64'(mq.size()));
      chk("R7 err_halt", 64'(err_halt), 64'(m_err));
      chk("R8 ovf_sticky", 64'(ovf_sticky), 64'(m_ovf));
      reg_wr = 0; reg_be = '0; desc_done = 0; err_clear = 0;
   endtask

   task automatic wr(input logic [7:0] be, input logic [63:0] d, input logic en);
      reg_wr = 1; reg_be = be; reg_wdata = d; ext_addr_en = en;
      tick();
   endtask

   task automatic done_pulse();
      desc_done = 1;
      tick();
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #3;
      chk("R1 launch in reset", 64'(launch_valid), 64'd0);
      #20 rst_n = 1'b1;
      #1;
      tick();
      chk("R1 count after reset", 64'(fill_count), 64'd0);
      chk("R1 flags after reset", 64'({err_halt, ovf_sticky}), 64'd0);

      // R2: writes without byte lane 0 push nothing
      wr(8'h0E, 64'h0000_0000_1234_5600, 1'b0);
      tick();
      chk("R2 no push without lane 0", 64'(fill_count), 64'd0);
      chk("R2 no launch without lane 0", 64'(launch_valid), 64'd0);

      // R1: staged portion is zero after reset
      wr(8'h01, 64'h0000_0000_0000_0040, 1'b1);
      tick();
      chk("R1 staged portion reset to zero", 64'(last_launch), 64'h0_0000_0040);
      done_pulse(); tick();

      // R5: ext disabled forces zero even with staged value; R3 reserved bits ignored
      wr(8'h10, 64'h0000_000A_0000_0000, 1'b0);
      wr(8'h0F, 64'hFFFF_FFF0_0000_1000, 1'b0);
      tick();
      chk("R5 upper bits zero", 64'(last_launch), 64'h0_0000_1000);
      done_pulse(); tick();

      // R4: same-write extended portion used; R3 reserved bits high ignored
      wr(8'hFF, 64'hFFFF_FFF5_0000_2000, 1'b1);
      tick();
      chk("R4 same-write ext", 64'(last_launch), 64'h5_0000_2000);
      chk("R3 reserved bits ignored", 64'(last_launch[35:32]), 64'h5);
      done_pulse(); tick();

      // R4: earlier staged portion persists
      wr(8'h10, 64'h0000_0007_0000_0000, 1'b1);
      wr(8'h01, 64'h0000_0000_0000_3000, 1'b1);
      tick();
      chk("R4 staged ext", 64'(last_launch), 64'h7_0000_3000);
      done_pulse(); tick();

      // R8: fill while busy, overflow at 25th
      wr(8'h01, 64'h0000_0000_0000_0100, 1'b1);
      for (int i = 1; i <= 25; i++) wr(8'h0F, 64'h0000_0000_0001_0000 + 64'(i), 1'b0);
      chk("R8 count saturates", 64'(fill_count), 64'd24);
      chk("R8 overflow flag", 64'(ovf_sticky), 64'd1);

      // R8: push at full accepted when a launch pops the same cycle
      done_pulse();
      wr(8'h01, 64'h0000_0000_0002_0000, 1'b0);
      chk("R8 push with pop at full", 64'(fill_count), 64'd24);

      // R7: zero address halts, queue kept
      wr(8'h01, 64'h0000_0000_0000_0000, 1'b0);
      chk("R7 err set", 64'(err_halt), 64'd1);
      chk("R7 zero not queued", 64'(fill_count), 64'd24);
      done_pulse(); tick(); tick();
      chk("R7 no launch when halted", 64'(fill_count), 64'd24);

      // R9: clear releases flags and launches resume
      err_clear = 1; tick();
      chk("R9 err cleared", 64'(err_halt), 64'd0);
      chk("R9 ovf cleared", 64'(ovf_sticky), 64'd0);
      tick();
      chk("R9 launch resumes", 64'(last_launch), 64'h0_0001_0002);

      // R6: drain in order
      for (int i = 0; i < 26; i++) begin done_pulse(); tick(); end
      chk("R6 drained", 64'(fill_count), 64'd0);

      // R9: clear and zero write together leave error set
      err_clear = 1;
      wr(8'h01, 64'h0, 1'b0);
      chk("R9 set wins over clear", 64'(err_halt), 64'd1);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule